// File: doc/BRIEF.md
# Power-down hold wrapper for a registered logic core

This block wraps a small registered logic core and gives it a pin-controlled power-down mode. A shared input pin plays one of two roles. A configuration bit, captured while reset is asserted, picks the role. With the bit clear, the pin is an ordinary data input and feeds the top bit of the core's input word. With the bit set, the pin is a power-down request and never reaches the core as data.

While power-down is requested, every clock edge is refused. The input hold registers keep the last accepted data and output-enable levels, and the core state does not move. Both the registered outputs and the combinational outputs stay frozen, and an output that was disabled (high impedance) stays disabled. When the request drops, one further edge is still refused, so no edge that was pending during power-down is acted on. From then on the core resumes from the held state.

At reset every register is cleared to low. The registered outputs then show the configured output polarity mask.

Top module: `pdhold_unit`

## Requirements
- R1: While reset is asserted, all registers are low: `reg_out` equals the polarity mask `POL_MASK` (default 9'h0A5), `comb_out` is 0 and `out_oe` is 0.
- R2: With the configuration bit clear, `pd_pin` is captured as bit 8 of the held input word at every accepted edge, and it never freezes the block. With the bit set, that held bit is always 0.
- R3: With the configuration bit set and `pd_pin` high at a clock edge, that edge is refused: the core state, `reg_out` and `comb_out` do not change.
- R4: Values on `din` and `oe_in` applied only during power-down have no effect on the outputs or on the state after power-down is released.
- R5: During power-down `out_oe` is frozen, so an output that was disabled stays disabled for the whole power-down.
- R6: The first clock edge after `pd_pin` falls is also refused, and updates resume at the second edge.
- R7: The configuration bit is sampled only while reset is asserted. Changes on `cfg_pd_en` after reset release have no effect.
- R8: At each accepted edge the held word H becomes {shared bit, `din`} and `out_oe` takes `oe_in`. The state Q becomes rotate-left-by-one(Q) XOR the previous H. The outputs are `reg_out` = Q XOR `POL_MASK` and `comb_out` = H XOR Q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_pd_en | input | 1 | Role of the shared pin: 1 for power-down request, 0 for data. Sampled during reset |
| pd_pin | input | 1 | Shared pin: power-down request or data bit 8 |
| din | input | 8 | Data inputs to the core |
| oe_in | input | 9 | Output-enable inputs, one per output |
| reg_out | output | 9 | Registered outputs after the polarity mask |
| comb_out | output | 9 | Combinational outputs derived from held inputs and state |
| out_oe | output | 9 | Held output enables; 0 means the output is high impedance |

## Verification
The assertions assume that `cfg_pd_en` matters only while reset is low. They also assume that all inputs are settled at each rising clock edge, since the block samples `pd_pin` at the edge rather than asynchronously. The stimulus changes every input only at falling edges. It changes the configuration bit only between resets, except in one deliberate case that checks R7. In the random phases, power-down comes in bursts of random length so that entry, hold and the refused wake edge all occur many times.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  // Control bundle passed from the power-down controller to the datapath.
  typedef struct packed {
    logic cfg;    // captured role of the shared pin (1: power-down request)
    logic act;    // power-down requested at this edge
    logic wake;   // power-down was requested at the previous edge
    logic ce;     // clock enable for all held state
  } pdh_ctrl_t;

endpackage

// File: rtl/pdh_rst_sync.sv
module pdh_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = chain[STAGES-1];

endmodule

// File: rtl/pdh_ctrl.sv
module pdh_ctrl
  import pdh_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n_s,
  input  logic      cfg_pd_en,
  input  logic      pd_pin,
  output pdh_ctrl_t ctl,
  output logic      shared_bit
);

  logic cfg_q;
  logic cfg_d;
  logic wake_q;
  logic wake_d;
  logic act;

  // The role register is loaded only while reset holds, so it has no reset.
  always_comb begin
    cfg_d = rst_n_s ? cfg_q : cfg_pd_en;
  end

  always_ff @(posedge clk) begin
    cfg_q <= cfg_d;
  end

  assign act = cfg_q & pd_pin;

  always_comb begin
    wake_d = act;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) wake_q <= 1'b0;
    else          wake_q <= wake_d;
  end

  assign ctl.cfg  = cfg_q;
  assign ctl.act  = act;
  assign ctl.wake = wake_q;
  assign ctl.ce   = ~act & ~wake_q;

  // The shared pin feeds the array only in its data role.
  assign shared_bit = cfg_q ? 1'b0 : pd_pin;

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    rst_n_s |=> $stable(cfg_q)); // R7

endmodule

// File: rtl/pdh_hold.sv
module pdh_hold #(
  parameter int DW = 8,
  localparam int SW = DW + 1
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          ce,
  input  logic          cfg,
  input  logic          shared_bit,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] oe_in,
  output logic [SW-1:0] hold_q,
  output logic [SW-1:0] oe_q
);

  logic [SW-1:0] hold_d;
  logic [SW-1:0] oe_d;

  always_comb begin
    hold_d = hold_q;
    oe_d   = oe_q;
    if (ce) begin
      hold_d = {shared_bit, din};
      oe_d   = oe_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      hold_q <= '0;
      oe_q   <= '0;
    end else begin
      hold_q <= hold_d;
      oe_q   <= oe_d;
    end
  end

  AST_OE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ce |=> $stable(oe_q)); // R5

  AST_NO_SHARED_FEED: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg |-> !hold_q[SW-1]); // R2

endmodule

// File: rtl/pdh_core.sv
module pdh_core #(
  parameter int            SW       = 9,
  parameter logic [SW-1:0] POL_MASK = '0
) (
  input  logic          clk,
  input  logic          rst_n_s,
  input  logic          ce,
  input  logic [SW-1:0] hold_q,
  output logic [SW-1:0] reg_out,
  output logic [SW-1:0] comb_out
);

  logic [SW-1:0] st_q;
  logic [SW-1:0] st_d;
  logic [SW-1:0] rot;

  // Rotate left by one bit, built per bit.
  for (genvar i = 0; i < SW; i++) begin : g_rot
    if (i == 0) begin : g_wrap
      assign rot[i] = st_q[SW-1];
    end else begin : g_mid
      assign rot[i] = st_q[i-1];
    end
  end

  always_comb begin
    st_d = st_q;
    if (ce) st_d = rot ^ hold_q;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) st_q <= '0;
    else          st_q <= st_d;
  end

  assign reg_out  = st_q ^ POL_MASK;
  assign comb_out = hold_q ^ st_q;

  AST_STATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n_s)
    !ce |=> $stable(st_q)); // R3

endmodule

// File: rtl/pdhold_unit.sv
module pdhold_unit
  import pdh_pkg::*;
#(
  parameter int            DW       = 8,
  localparam int           SW       = DW + 1,
  parameter logic [SW-1:0] POL_MASK = 9'h0A5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_pd_en,
  input  logic          pd_pin,
  input  logic [DW-1:0] din,
  input  logic [SW-1:0] oe_in,
  output logic [SW-1:0] reg_out,
  output logic [SW-1:0] comb_out,
  output logic [SW-1:0] out_oe
);

  logic          rst_n_s;
  pdh_ctrl_t     ctl;
  logic          shared_bit;
  logic [SW-1:0] hold_q;

  pdh_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  pdh_ctrl u_ctrl (
    .clk        (clk),
    .rst_n_s    (rst_n_s),
    .cfg_pd_en  (cfg_pd_en),
    .pd_pin     (pd_pin),
    .ctl        (ctl),
    .shared_bit (shared_bit)
  );

  pdh_hold #(.DW(DW)) u_hold (
    .clk        (clk),
    .rst_n_s    (rst_n_s),
    .ce         (ctl.ce),
    .cfg        (ctl.cfg),
    .shared_bit (shared_bit),
    .din        (din),
    .oe_in      (oe_in),
    .hold_q     (hold_q),
    .oe_q       (out_oe)
  );

  pdh_core #(.SW(SW), .POL_MASK(POL_MASK)) u_core (
    .clk      (clk),
    .rst_n_s  (rst_n_s),
    .ce       (ctl.ce),
    .hold_q   (hold_q),
    .reg_out  (reg_out),
    .comb_out (comb_out)
  );

  AST_WAKE_REFUSED: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl.wake |=> ($stable(reg_out) && $stable(comb_out) && $stable(out_oe))); // R6

  AST_PD_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_n_s)
    ctl.act |=> ($stable(reg_out) && $stable(comb_out))); // R3

endmodule

// File: tb/pdhold_unit_bench.sv
module pdhold_unit_bench;

  localparam int            CLK_PERIOD = 10;
  localparam int            DW         = 8;
  localparam int            SW         = DW + 1;
  localparam logic [SW-1:0] POL        = 9'h0A5;

  logic          clk;
  logic          rst_n;
  logic          cfg_pd_en;
  logic          pd_pin;
  logic [DW-1:0] din;
  logic [SW-1:0] oe_in;
  logic [SW-1:0] reg_out;
  logic [SW-1:0] comb_out;
  logic [SW-1:0] out_oe;

  int n_chk;
  int n_bad;
  bit done;

  // Bench model of the requirements
  logic          m_cfg;
  logic          m_wake;
  logic [SW-1:0] m_q;
  logic [SW-1:0] m_h;
  logic [SW-1:0] m_oe;

  pdhold_unit #(.DW(DW), .POL_MASK(POL)) u_pdhold_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_pd_en (cfg_pd_en),
    .pd_pin    (pd_pin),
    .din       (din),
    .oe_in     (oe_in),
    .reg_out   (reg_out),
    .comb_out  (comb_out),
    .out_oe    (out_oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [SW-1:0] rotl1(input logic [SW-1:0] v);
    return {v[SW-2:0], v[SW-1]};
  endfunction

  function automatic logic [SW-1:0] exp_reg();
    return m_q ^ POL;
  endfunction

  function automatic logic [SW-1:0] exp_comb();
    return m_h ^ m_q;
  endfunction

  task automatic chk(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " reg_out"},  reg_out,  exp_reg());
    chk({tag, " comb_out"}, comb_out, exp_comb());
    chk({tag, " out_oe"},   out_oe,   m_oe);
  endtask

  // One clock: drive after a falling edge, update the model at the rising edge,
  // compare at the next falling edge.
  task automatic tick(input logic [DW-1:0] d, input logic [SW-1:0] o,
                      input logic p, input string tag);
    logic          act;
    logic          ce;
    logic [SW-1:0] nq;
    din    = d;
    oe_in  = o;
    pd_pin = p;
    @(posedge clk);
    act = m_cfg & p;
    ce  = !act && !m_wake;
    if (ce) begin
      nq   = rotl1(m_q) ^ m_h;
      m_h  = {(m_cfg ? 1'b0 : p), d};
      m_oe = o;
      m_q  = nq;
    end
    m_wake = act;
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic do_reset(input logic cfg);
    rst_n     = 1'b0;
    cfg_pd_en = cfg;
    pd_pin    = 1'b0;
    din       = '0;
    oe_in     = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset reg_out",  reg_out,  POL);
    chk("R1 reset comb_out", comb_out, '0);
    chk("R1 reset out_oe",   out_oe,   '0);
    rst_n  = 1'b1;
    m_cfg  = cfg;
    m_wake = 1'b0;
    m_q    = '0;
    m_h    = '0;
    m_oe   = '0;
    repeat (3) tick('0, '0, 1'b0, "R1 release");
  endtask

  task automatic random_run(input int cycles, input int pd_weight);
    int burst;
    burst = 0;
    for (int i = 0; i < cycles; i++) begin
      logic p;
      if (burst > 0) burst--;
      else if (($urandom % 16) < pd_weight) burst = 1 + ($urandom % 6);
      p = (burst > 0);
      if (m_cfg == 1'b0)              tick(DW'($urandom), SW'($urandom), p, "R2/R8 data role");
      else if (p || m_wake)           tick(DW'($urandom), SW'($urandom), p, "R3 power-down");
      else                            tick(DW'($urandom), SW'($urandom), p, "R8 update");
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [SW-1:0] snap_reg;
    logic [SW-1:0] snap_comb;
    logic [SW-1:0] snap_oe;
    n_chk = 0;
    n_bad = 0;
    void'($urandom(32'd20240611));
    rst_n     = 1'b0;
    cfg_pd_en = 1'b0;
    pd_pin    = 1'b0;
    din       = '0;
    oe_in     = '0;

    // Data role: pin high lands in bit 8 and nothing freezes.
    do_reset(1'b0);
    tick('0, '0, 1'b1, "R2 pin as data");
    chk("R2 comb_out bit 8", SW'(comb_out[SW-1]), SW'(1'b1));
    tick(8'h3C, 9'h1FF, 1'b1, "R2 pin as data, no freeze");
    random_run(200, 6);

    // Power-down role.
    do_reset(1'b1);
    random_run(600, 5);

    // Directed freeze, ignored toggles and refused wake edge.
    tick(8'h55, 9'h1FF, 1'b0, "R8 setup");
    tick(8'h55, 9'h1FF, 1'b0, "R8 setup");
    tick(8'h12, 9'h0F0, 1'b0, "R8 setup");
    snap_reg  = reg_out;
    snap_comb = comb_out;
    snap_oe   = out_oe;
    for (int k = 0; k < 5; k++) tick(DW'($urandom), SW'($urandom), 1'b1, "R3 hold");
    chk("R3 reg_out frozen",  reg_out,  snap_reg);
    chk("R3 comb_out frozen", comb_out, snap_comb);
    tick(8'hAA, 9'h00F, 1'b0, "R6 wake edge");
    chk("R6 reg_out after wake edge",  reg_out,  snap_reg);
    chk("R6 comb_out after wake edge", comb_out, snap_comb);
    chk("R6 out_oe after wake edge",   out_oe,   snap_oe);
    tick(8'h0F, 9'h111, 1'b0, "R4 first accepted edge");
    tick(8'h0F, 9'h111, 1'b0, "R4 second accepted edge");

    // Disabled outputs stay disabled through power-down.
    tick(8'h00, 9'h000, 1'b0, "R5 disable");
    for (int k = 0; k < 4; k++) begin
      tick(DW'($urandom), 9'h1FF, 1'b1, "R5 hold");
      chk("R5 out_oe stays off", out_oe, '0);
    end
    tick(8'h00, 9'h1FF, 1'b0, "R5 wake edge");
    chk("R5 out_oe off at wake edge", out_oe, '0);
    tick(8'h00, 9'h1FF, 1'b0, "R5 resumed");
    chk("R5 out_oe enabled after resume", out_oe, 9'h1FF);

    // Role change after reset is ignored: pin still means power-down.
    cfg_pd_en = 1'b0;
    snap_reg  = reg_out;
    for (int k = 0; k < 3; k++) tick(DW'($urandom), SW'($urandom), 1'b1, "R7 role kept");
    chk("R7 reg_out frozen despite cfg change", reg_out, snap_reg);
    random_run(100, 5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule